// File: doc/BRIEF.md
# Trace Capture Trigger and Direction Controller

This block decides when a bus trace recorder is allowed to write, and at which resolution. A small set of configuration inputs (enable, capture direction, resolution mode, address match value and mask, re-trigger period) sets up a capture. The controller then watches the bus address, transfer type and ready signal, and the full flag from the trace buffer. It drives a trace enable, the active resolution mode, a segment-start pulse, a wrap permission for the buffer and a completion flag.

Two capture directions exist. Forward capture arms on enable, begins at the first matching transfer and ends when the buffer reports full. Backward capture begins as soon as the block is enabled and lets the buffer overwrite its oldest entries. It ends at the first matching transfer, so the buffer holds the history that led up to that event. In either direction, a non-zero period re-starts the trace at a fixed cycle interval. Every new segment raises a one-cycle pulse, so a downstream compressor can reload its reference state. Each segment also samples the requested mode, which is how the resolution changes while a capture runs.

All outputs are plain registered control pins. No data stream passes through the block, so there is no valid/ready interface and no back-pressure.

Top module: `trace_trig_ctrl`

## Requirements
- R1: While reset is asserted, and in every cycle that follows a cycle with `cfg_enable` low, `trace_en`, `seg_start`, `wrap_en` and `done` are 0 and `trace_mode` is 0.
- R2: A transfer matches only when `bus_hready` is 1, `bus_htrans` is 2'b10 (first beat) or 2'b11 (following beat), and `(bus_haddr & cfg_mask) == (cfg_match & cfg_mask)`. Transfer types 2'b00 and 2'b01 never match.
- R3: In forward direction (`cfg_dir`=0), the block waits after enable with `trace_en` low. A match sampled at a clock edge makes `trace_en` high from that edge on, and `seg_start` is high for that first cycle.
- R4: In forward direction, `buf_full` sampled high while tracing makes `trace_en` low and `done` high from that edge on. `wrap_en` is never high in forward direction.
- R5: In backward direction (`cfg_dir`=1), the first edge with `cfg_enable` high starts tracing. `trace_en`, `wrap_en` and `seg_start` are high after that edge, and `buf_full` has no effect on the capture.
- R6: In backward direction, a match sampled while tracing ends the capture: `trace_en` and `wrap_en` go low and `done` goes high at that edge.
- R7: With `cfg_period` = P > 0, while tracing continues, `seg_start` pulses for one cycle every P cycles after a segment start (P = 1 pulses every cycle).
- R8: With `cfg_period` = 0, no segment start occurs after the first one.
- R9: `trace_mode` takes the value of `cfg_mode` at each segment start and holds it between starts, whatever `cfg_mode` does meanwhile.
- R10: `done` stays high, and neither matches nor a change of `cfg_dir` restart tracing, until `cfg_enable` is low. The direction is sampled when the block leaves the disabled state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Capture enable; low returns to disabled |
| cfg_dir | input | 1 | 0 forward (start on match), 1 backward (stop on match) |
| cfg_mode | input | MODE_W | Resolution mode for the next segment |
| cfg_match | input | AW | Address compare value |
| cfg_mask | input | AW | Address compare mask, 1 = bit compared |
| cfg_period | input | PERIOD_W | Re-trigger interval in cycles, 0 = off |
| bus_haddr | input | AW | Observed bus address |
| bus_htrans | input | 2 | Observed transfer type |
| bus_hready | input | 1 | Observed ready |
| buf_full | input | 1 | Trace buffer full |
| trace_en | output | 1 | Trace writes allowed |
| trace_mode | output | MODE_W | Mode of the current segment |
| seg_start | output | 1 | One-cycle pulse at each segment start |
| wrap_en | output | 1 | Buffer may overwrite oldest entries |
| done | output | 1 | Capture finished |

## Verification
Every output is a register, so a stimulus presented before a clock edge shows its effect in the cycle right after that edge, and never later. The bench drives bus and buffer inputs just after a falling edge and queues the output word expected after the next rising edge. A monitor compares that word at the following falling edge. Re-trigger pulses are counted in whole cycles from the segment start: a period of P gives a pulse on the P-th cycle after the previous pulse. Configuration changes are applied in the same half cycle as the bus stimulus, so they act at exactly the edge the expected value assumes.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FIN   = 2'd3
  } trc_state_e;

  localparam logic [1:0] XFER_FIRST  = 2'b10;
  localparam logic [1:0] XFER_FOLLOW = 2'b11;

  localparam logic DIR_FWD = 1'b0;
  localparam logic DIR_BWD = 1'b1;
endpackage

// File: rtl/trc_addr_match.sv
module trc_addr_match #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hready,
  input  logic [AW-1:0] match_val,
  input  logic [AW-1:0] match_mask,
  output logic          hit
);
  import trc_pkg::*;

  logic active_xfer;
  logic addr_eq;

  assign active_xfer = (htrans == XFER_FIRST) || (htrans == XFER_FOLLOW);
  assign addr_eq     = ((haddr & match_mask) == (match_val & match_mask));
  assign hit         = hready && active_xfer && addr_eq;
endmodule

// File: rtl/trc_period_timer.sv
module trc_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic [PW-1:0] period,
  output logic          tick
);
  localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] cnt;

  assign tick = run && (period != '0) && (cnt == period - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || tick) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/trc_seq_fsm.sv
module trc_seq_fsm #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dir,
  input  logic [MW-1:0] mode,
  input  logic          hit,
  input  logic          full,
  input  logic          tick,
  output logic          run,
  output logic          start,
  output logic          trace_en,
  output logic          wrap_en,
  output logic          done,
  output logic          seg_start,
  output logic [MW-1:0] trace_mode
);
  import trc_pkg::*;

  trc_state_e    state_q, state_n;
  logic          dir_q;
  logic          stop;
  logic          seg_q;
  logic [MW-1:0] mode_q;

  always_comb begin
    start   = 1'b0;
    stop    = 1'b0;
    state_n = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (enable) begin
          if (dir == DIR_BWD) begin
            start   = 1'b1;
            state_n = ST_CAPT;
          end else begin
            state_n = ST_ARMED;
          end
        end
      end
      ST_ARMED: begin
        if (!enable) begin
          state_n = ST_OFF;
        end else if (hit) begin
          start   = 1'b1;
          state_n = ST_CAPT;
        end
      end
      ST_CAPT: begin
        if (!enable) begin
          state_n = ST_OFF;
        end else begin
          stop = (dir_q == DIR_BWD) ? hit : full;
          if (stop) state_n = ST_FIN;
        end
      end
      ST_FIN: begin
        if (!enable) state_n = ST_OFF;
      end
      default: state_n = ST_OFF;
    endcase
  end

  assign run = (state_q == ST_CAPT) && enable && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      dir_q   <= DIR_FWD;
      seg_q   <= 1'b0;
      mode_q  <= '0;
    end else begin
      state_q <= state_n;
      seg_q   <= start || tick;
      if (state_q == ST_OFF && enable) dir_q <= dir;
      if (state_n == ST_OFF) begin
        mode_q <= '0;
      end else if (start || tick) begin
        mode_q <= mode;
      end
    end
  end

  assign trace_en   = (state_q == ST_CAPT);
  assign wrap_en    = (state_q == ST_CAPT) && (dir_q == DIR_BWD);
  assign done       = (state_q == ST_FIN);
  assign seg_start  = seg_q;
  assign trace_mode = mode_q;
endmodule

// File: rtl/trace_trig_ctrl.sv
module trace_trig_ctrl #(
  parameter int AW       = 32,
  parameter int MODE_W   = 3,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic                cfg_dir,
  input  logic [MODE_W-1:0]   cfg_mode,
  input  logic [AW-1:0]       cfg_match,
  input  logic [AW-1:0]       cfg_mask,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [AW-1:0]       bus_haddr,
  input  logic [1:0]          bus_htrans,
  input  logic                bus_hready,
  input  logic                buf_full,
  output logic                trace_en,
  output logic [MODE_W-1:0]   trace_mode,
  output logic                seg_start,
  output logic                wrap_en,
  output logic                done
);
  logic hit;
  logic run;
  logic start;
  logic tick;

  trc_addr_match #(.AW(AW)) u_match (
    .haddr      (bus_haddr),
    .htrans     (bus_htrans),
    .hready     (bus_hready),
    .match_val  (cfg_match),
    .match_mask (cfg_mask),
    .hit        (hit)
  );

  trc_period_timer #(.PW(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start),
    .run    (run),
    .period (cfg_period),
    .tick   (tick)
  );

  trc_seq_fsm #(.MW(MODE_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .dir        (cfg_dir),
    .mode       (cfg_mode),
    .hit        (hit),
    .full       (buf_full),
    .tick       (tick),
    .run        (run),
    .start      (start),
    .trace_en   (trace_en),
    .wrap_en    (wrap_en),
    .done       (done),
    .seg_start  (seg_start),
    .trace_mode (trace_mode)
  );
endmodule

// File: rtl/trace_trig_ctrl_chk.sv
module trace_trig_ctrl_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              buf_full,
  input logic              trace_en,
  input logic [MODE_W-1:0] trace_mode,
  input logic              seg_start,
  input logic              wrap_en,
  input logic              done
);
  AST_SEG_IN_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    seg_start |-> trace_en); // R7

  AST_WRAP_IN_TRACE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_en |-> trace_en); // R5

  AST_FIN_NOT_TRACING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !trace_en); // R4

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!trace_en && !done && !seg_start && !wrap_en)); // R1

  AST_FIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_enable) |=> done); // R10

  AST_FWD_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && !wrap_en && buf_full) |=> !trace_en); // R4

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && $past(trace_en) && !seg_start) |-> $stable(trace_mode)); // R9

  AST_FIRST_CYCLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trace_en) |-> seg_start); // R3
endmodule

bind trace_trig_ctrl trace_trig_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_enable (cfg_enable),
  .buf_full   (buf_full),
  .trace_en   (trace_en),
  .trace_mode (trace_mode),
  .seg_start  (seg_start),
  .wrap_en    (wrap_en),
  .done       (done)
);

// File: tb/sim_trace_trig_ctrl.sv
module sim_trace_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_dir = 1'b0;
  logic [2:0]  cfg_mode = 3'd0;
  logic [31:0] cfg_match = 32'h0000_1000;
  logic [31:0] cfg_mask = 32'hFFFF_FF00;
  logic [15:0] cfg_period = 16'd0;
  logic [31:0] bus_haddr = 32'h0;
  logic [1:0]  bus_htrans = 2'b00;
  logic        bus_hready = 1'b1;
  logic        buf_full = 1'b0;
  logic        trace_en, seg_start, wrap_en, done;
  logic [2:0]  trace_mode;

  int checks = 0;
  int errors = 0;
  logic [6:0] exp_q[$];
  string      req_q[$];

  always #10 clk = ~clk;

  trace_trig_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_dir(cfg_dir),
    .cfg_mode(cfg_mode), .cfg_match(cfg_match), .cfg_mask(cfg_mask),
    .cfg_period(cfg_period), .bus_haddr(bus_haddr), .bus_htrans(bus_htrans),
    .bus_hready(bus_hready), .buf_full(buf_full), .trace_en(trace_en),
    .trace_mode(trace_mode), .seg_start(seg_start), .wrap_en(wrap_en), .done(done)
  );

  function automatic logic [6:0] ex(input logic en, input logic seg, input logic wr,
                                    input logic dn, input logic [2:0] md);
    return {en, seg, wr, dn, md};
  endfunction

  // driver: inputs for the coming rising edge, expected outputs after it
  task automatic cyc(input logic [31:0] a, input logic [1:0] t, input logic r,
                     input logic f, input logic [6:0] e, input string req);
    bus_haddr = a; bus_htrans = t; bus_hready = r; buf_full = f;
    exp_q.push_back(e);
    req_q.push_back(req);
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input logic [6:0] e, input string req);
    cyc(32'h0000_2000, 2'b00, 1'b1, 1'b0, e, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e;
      logic [6:0] act;
      string      rq;
      e   = exp_q.pop_front();
      rq  = req_q.pop_front();
      act = {trace_en, seg_start, wrap_en, done, trace_mode};
      checks++;
      if (act !== e) begin
        errors++;
        $display("FAIL %s: {en,seg,wrap,done,mode} actual=%b expected=%b", rq, act, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1: watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if ({trace_en, seg_start, wrap_en, done, trace_mode} !== 7'b0) begin
      errors++;
      $display("FAIL R1: reset outputs actual=%b expected=%b",
               {trace_en, seg_start, wrap_en, done, trace_mode}, 7'b0);
    end
    rst_n = 1'b1;
    idle(ex(0,0,0,0,0), "R1 disabled");

    // forward capture, no re-trigger
    cfg_enable = 1'b1; cfg_dir = 1'b0; cfg_mode = 3'd3; cfg_period = 16'd0;
    idle(ex(0,0,0,0,0), "R3 armed");
    cyc(32'h0000_1004, 2'b00, 1'b1, 1'b0, ex(0,0,0,0,0), "R2 idle type");
    cyc(32'h0000_1004, 2'b01, 1'b1, 1'b0, ex(0,0,0,0,0), "R2 busy type");
    cyc(32'h0000_1004, 2'b10, 1'b0, 1'b0, ex(0,0,0,0,0), "R2 not ready");
    cyc(32'h0000_2004, 2'b10, 1'b1, 1'b0, ex(0,0,0,0,0), "R2 masked mismatch");
    cyc(32'h0000_10FF, 2'b11, 1'b1, 1'b0, ex(1,1,0,0,3), "R3 start on match");
    cfg_mode = 3'd5;
    idle(ex(1,0,0,0,3), "R9 mode held");
    cyc(32'h0000_1000, 2'b10, 1'b1, 1'b0, ex(1,0,0,0,3), "R8 no restart");
    idle(ex(1,0,0,0,3), "R8 no pulse");
    cyc(32'h0000_2000, 2'b00, 1'b1, 1'b1, ex(0,0,0,1,3), "R4 full stops");
    cyc(32'h0000_1000, 2'b10, 1'b1, 1'b0, ex(0,0,0,1,3), "R10 done sticky");
    cfg_dir = 1'b1;
    idle(ex(0,0,0,1,3), "R10 dir ignored");
    cfg_enable = 1'b0;
    idle(ex(0,0,0,0,0), "R1 disable clears");

    // backward capture, period 4
    cfg_enable = 1'b1; cfg_dir = 1'b1; cfg_mode = 3'd2; cfg_period = 16'd4;
    idle(ex(1,1,1,0,2), "R5 start at enable");
    cfg_mode = 3'd6;
    cyc(32'h0000_2000, 2'b00, 1'b1, 1'b1, ex(1,0,1,0,2), "R5 full ignored");
    idle(ex(1,0,1,0,2), "R7 gap");
    idle(ex(1,0,1,0,2), "R7 gap");
    idle(ex(1,1,1,0,6), "R7 period pulse");
    idle(ex(1,0,1,0,6), "R9 new mode held");
    idle(ex(1,0,1,0,6), "R7 gap");
    idle(ex(1,0,1,0,6), "R7 gap");
    idle(ex(1,1,1,0,6), "R7 second pulse");
    cyc(32'h0000_1010, 2'b10, 1'b1, 1'b0, ex(0,0,0,1,6), "R6 match stops");
    idle(ex(0,0,0,1,6), "R10 done holds");
    cfg_enable = 1'b0;
    idle(ex(0,0,0,0,0), "R1 disable clears");

    // forward capture, period 1
    cfg_enable = 1'b1; cfg_dir = 1'b0; cfg_mode = 3'd1; cfg_period = 16'd1;
    idle(ex(0,0,0,0,0), "R3 armed");
    cyc(32'h0000_1080, 2'b10, 1'b1, 1'b0, ex(1,1,0,0,1), "R3 start on match");
    cfg_mode = 3'd4;
    idle(ex(1,1,0,0,4), "R7 period one");
    idle(ex(1,1,0,0,4), "R7 period one");
    cyc(32'h0000_2000, 2'b00, 1'b1, 1'b1, ex(0,0,0,1,4), "R4 full stops");
    cfg_enable = 1'b0;
    idle(ex(0,0,0,0,0), "R1 disable clears");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule